// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a bus-attached parallel I/O controller that gives a host three byte-wide ports, called A, B and C. Port C is treated as two nibble-wide groups, an upper nibble and a lower nibble, and each nibble has its own direction. The host reaches the block through an active-low chip select, active-low read and write strobes, a two-bit register address and a byte-wide data bus. Every port pin is modelled as three separate signals: an input value, an output latch value and an output enable.

A write to the control address does one of two things, depending on data bit 7:

- **Bit 7 set:** the write is a mode definition. It sets the direction of all four groups at once, records the mode fields, and clears every output latch.
- **Bit 7 clear:** the write is a single-bit command. It sets or clears one port C latch bit and leaves every other bit alone.

Only simple I/O is carried out. The handshake mode fields are decoded and kept, and they can be read back, but they do not change pin behaviour.

All logic runs on a single clock. The bus strobes are sampled on that clock. A write takes effect on the first clock edge at which write is seen high after being low, while chip select is still low.

Top module: `ppio_ctrl`

## Requirements
- R1: After synchronous reset, every output enable is low, every output latch is zero, and a read of the control address (addr 3) returns 0x9B.
- R2: Address 0 writes the port A latch, address 1 writes port B and address 2 writes port C. The new latch value appears on the output port one clock after the write is captured.
- R3: The mode word 0x80 makes every group an output, so all 24 output enables are high.
- R4: In a mode word, a 1 makes the group an input and a 0 makes it an output. The direction bits are:
  - bit 4 for port A
  - bit 3 for the upper C nibble
  - bit 1 for port B
  - bit 0 for the lower C nibble
- R5: A read of the control address returns bit 7 as 1, followed by the stored mode fields: bits 6:5 for the group A mode and bit 2 for the port B mode. The direction bits read back at the positions given in R4.
- R6: Every mode word (bit 7 set, written to address 3) clears all three output latches to zero.
- R7: A write to address 3 with bit 7 clear is a single-bit command. Data bits 3:1 select the port C bit, and data bit 0 is the value (1 sets, 0 clears). The other port C bits, ports A and B, and the stored control word do not change.
- R8: A read of a port returns, per group, the input pins when that group is an input and the output latch when it is an output.
- R9: The data output enable is high exactly while chip select and read are both low. When it is low, the data output is zero.
- R10: A write is captured only on a low-to-high transition of the write strobe while chip select is low. A strobe with chip select high changes nothing, and holding write low changes nothing until it rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| din | input | PORT_W | Write data from host |
| dout | output | PORT_W | Read data to host |
| dout_oe | output | 1 | Read data drive enable |
| pa_in | input | PORT_W | Port A pin values |
| pa_out | output | PORT_W | Port A output latch |
| pa_oe | output | PORT_W | Port A output enables |
| pb_in | input | PORT_W | Port B pin values |
| pb_out | output | PORT_W | Port B output latch |
| pb_oe | output | PORT_W | Port B output enables |
| pc_in | input | PORT_W | Port C pin values |
| pc_out | output | PORT_W | Port C output latch |
| pc_oe | output | PORT_W | Port C output enables |

## Verification
The bench builds the block with its default PORT_W of 8, which is the only width that matches the byte-wide control word layout. At this width the bit-select field of the single-bit command covers all eight port C bits, so the bench reaches both the top bit and an inner bit. The nibble split of port C falls at bit 4, so mode words that give the two C nibbles opposite directions show a mixed read of pins and latches inside one byte.

// File: rtl/ppio_pkg.sv
// Package for the parallel port controller.
// Holds the register address codes, the layout of the stored
// configuration word and its reset value.
// Assumption: the control word is always a byte, whatever the port width.
package ppio_pkg;

    typedef enum logic [1:0] {
        ADR_A   = 2'd0,
        ADR_B   = 2'd1,
        ADR_C   = 2'd2,
        ADR_CTL = 2'd3
    } ppio_addr_e;

    // Stored configuration, packed so that it lines up with control bits 6:0.
    typedef struct packed {
        logic [1:0] mode_a;   // bits 6:5, mode of group A and upper C
        logic       a_in;     // bit 4, port A is input
        logic       cu_in;    // bit 3, upper C nibble is input
        logic       b_mode;   // bit 2, mode of port B
        logic       b_in;     // bit 1, port B is input
        logic       cl_in;    // bit 0, lower C nibble is input
    } ppio_cfg_t;

    // Reset configuration: mode 0 everywhere, every group an input.
    localparam ppio_cfg_t CFG_RESET = '{mode_a: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                        b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

endpackage

// File: rtl/ppio_bus_sync.sv
// Bus write detector.
// Samples the write strobe on the clock and raises a one-cycle pulse on the
// first edge at which write is seen high after being low, qualified by chip
// select still being low at that edge.
// Assumption: the host holds addr and data stable through the rising strobe.
module ppio_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    output logic wr_pulse
);

    logic wr_n_q;

    // Remember the strobe level seen at the previous clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_n_q <= 1'b1;
        else        wr_n_q <= wr_n;
    end

    // A capture happens when the strobe rises while the chip is selected.
    always_comb wr_pulse = wr_n && !wr_n_q && !cs_n;

endmodule

// File: rtl/ppio_cfg_reg.sv
// Configuration register.
// Splits a captured control-address write into a mode definition (bit 7 set)
// or a single-bit command (bit 7 clear). Only a mode definition updates the
// stored configuration.
// Assumption: wr_pulse lasts one cycle per host write.
module ppio_cfg_reg
    import ppio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ppio_cfg_t         cfg,
    output logic              mode_def,
    output logic              bit_cmd
);

    logic ctl_hit;

    // Classify the kind of control write being made.
    always_comb begin
        ctl_hit  = wr_pulse && (wr_addr == ADR_CTL);
        mode_def = ctl_hit && wr_data[7];
        bit_cmd  = ctl_hit && !wr_data[7];
    end

    // Store the configuration on a mode definition write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg <= CFG_RESET;
        else if (mode_def) cfg <= ppio_cfg_t'(wr_data[6:0]);
    end

endmodule

// File: rtl/ppio_port_latch.sv
// Output latch for one port.
// It is loaded by a write to its own address and cleared by a mode
// definition. When BIT_CMD_EN is set, it also obeys the single-bit command
// (data bits SEL_W:1 pick the bit, data bit 0 gives the value).
// Assumption: only one of clear, bit command and write occurs per cycle.
module ppio_port_latch
    import ppio_pkg::*;
#(
    parameter int         PORT_W     = 8,
    parameter logic [1:0] MY_ADDR    = 2'd0,
    parameter bit         BIT_CMD_EN = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_pulse,
    input  logic [1:0]        wr_addr,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              clr_all,
    input  logic              bit_cmd,
    output logic [PORT_W-1:0] lat
);

    localparam int SEL_W = $clog2(PORT_W);

    logic              own_wr;
    logic [PORT_W-1:0] bit_mask;
    logic              bit_go;

    // Decode a direct write to this port's own address.
    always_comb own_wr = wr_pulse && (wr_addr == MY_ADDR);

    generate
        if (BIT_CMD_EN) begin : g_bitcmd
            logic [SEL_W-1:0] sel;
            // Turn the command's bit index into a one-hot mask.
            always_comb begin
                sel      = wr_data[SEL_W:1];
                bit_mask = '0;
                bit_mask[sel] = 1'b1;
                bit_go   = bit_cmd;
            end
        end else begin : g_nobit
            // This port has no single-bit access.
            always_comb begin
                bit_mask = '0;
                bit_go   = 1'b0;
            end
        end
    endgenerate

    // Update the latch: a clear wins, then the bit command, then a plain write.
    always_ff @(posedge clk) begin
        if (!rst_n)       lat <= '0;
        else if (clr_all) lat <= '0;
        else if (bit_go)  lat <= wr_data[0] ? (lat | bit_mask) : (lat & ~bit_mask);
        else if (own_wr)  lat <= wr_data;
    end

endmodule

// File: rtl/ppio_ctrl.sv
// Programmable parallel port controller, top level.
// Three ports, with port C split into two nibble groups, a configuration
// register, pin direction control and a host read multiplexer.
// Assumption: PORT_W is 8 so that the fixed control word layout fits.
module ppio_ctrl
    import ppio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [1:0]        addr,
    input  logic [PORT_W-1:0] din,
    output logic [PORT_W-1:0] dout,
    output logic              dout_oe,
    input  logic [PORT_W-1:0] pa_in,
    output logic [PORT_W-1:0] pa_out,
    output logic [PORT_W-1:0] pa_oe,
    input  logic [PORT_W-1:0] pb_in,
    output logic [PORT_W-1:0] pb_out,
    output logic [PORT_W-1:0] pb_oe,
    input  logic [PORT_W-1:0] pc_in,
    output logic [PORT_W-1:0] pc_out,
    output logic [PORT_W-1:0] pc_oe
);

    localparam int NIB_W = PORT_W / 2;

    logic      wr_pulse;
    logic      mode_def;
    logic      bit_cmd;
    ppio_cfg_t cfg;

    ppio_bus_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .wr_pulse (wr_pulse)
    );

    ppio_cfg_reg #(.DATA_W(PORT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_pulse (wr_pulse),
        .wr_addr  (addr),
        .wr_data  (din),
        .cfg      (cfg),
        .mode_def (mode_def),
        .bit_cmd  (bit_cmd)
    );

    ppio_port_latch #(.PORT_W(PORT_W), .MY_ADDR(ADR_A), .BIT_CMD_EN(1'b0)) u_lat_a (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(addr), .wr_data(din),
        .clr_all(mode_def), .bit_cmd(bit_cmd), .lat(pa_out)
    );

    ppio_port_latch #(.PORT_W(PORT_W), .MY_ADDR(ADR_B), .BIT_CMD_EN(1'b0)) u_lat_b (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(addr), .wr_data(din),
        .clr_all(mode_def), .bit_cmd(bit_cmd), .lat(pb_out)
    );

    ppio_port_latch #(.PORT_W(PORT_W), .MY_ADDR(ADR_C), .BIT_CMD_EN(1'b1)) u_lat_c (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(addr), .wr_data(din),
        .clr_all(mode_def), .bit_cmd(bit_cmd), .lat(pc_out)
    );

    // Drive the pin enables from the stored group directions.
    always_comb begin
        pa_oe = {PORT_W{~cfg.a_in}};
        pb_oe = {PORT_W{~cfg.b_in}};
        pc_oe = {{NIB_W{~cfg.cu_in}}, {NIB_W{~cfg.cl_in}}};
    end

    // Host read mux: pins for input groups, latches for output groups.
    always_comb begin
        dout_oe = !cs_n && !rd_n;
        dout    = '0;
        if (dout_oe) begin
            unique case (addr)
                ADR_A:   dout = cfg.a_in ? pa_in : pa_out;
                ADR_B:   dout = cfg.b_in ? pb_in : pb_out;
                ADR_C:   dout = {cfg.cu_in ? pc_in[PORT_W-1:NIB_W] : pc_out[PORT_W-1:NIB_W],
                                 cfg.cl_in ? pc_in[NIB_W-1:0]      : pc_out[NIB_W-1:0]};
                default: dout = PORT_W'({1'b1, cfg});
            endcase
        end
    end

endmodule

// File: rtl/ppio_ctrl_chk.sv
// Assertion checker for the parallel port controller, bound to the top.
// Looks only at ports and relates bus activity to later pin state.
module ppio_ctrl_chk #(
    parameter int PORT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic [1:0]        addr,
    input logic [PORT_W-1:0] din,
    input logic [PORT_W-1:0] dout,
    input logic              dout_oe,
    input logic [PORT_W-1:0] pa_out,
    input logic [PORT_W-1:0] pb_out,
    input logic [PORT_W-1:0] pc_out,
    input logic [PORT_W-1:0] pa_oe,
    input logic [PORT_W-1:0] pb_oe
);

    // R9
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!dout_oe && dout == '0));

    // R4
    group_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pa_oe == '0) || (pa_oe == '1)) && ((pb_oe == '0) || (pb_oe == '1)));

    // R6
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_n) && wr_n && !cs_n && addr == 2'd3 && din[7])
        |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

    // R7
    bit_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_n) && wr_n && !cs_n && addr == 2'd3 && !din[7])
        |=> ($countones(pc_out ^ $past(pc_out)) <= 1 && $stable(pa_out) && $stable(pb_out)));

    // R10
    deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)));

endmodule

bind ppio_ctrl ppio_ctrl_chk #(.PORT_W(PORT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
    .din(din), .dout(dout), .dout_oe(dout_oe), .pa_out(pa_out), .pb_out(pb_out),
    .pc_out(pc_out), .pa_oe(pa_oe), .pb_oe(pb_oe)
);

// File: tb/tb_ppio_ctrl.sv
// Self-checking bench for the parallel port controller.
module tb_ppio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 5;
    localparam logic [7:0] VEC_CTL [NVEC] = '{8'h80, 8'h9B, 8'h8A, 8'h91, 8'hE4};
    localparam logic [7:0] LAT_A = 8'h55, LAT_B = 8'hA5, LAT_C = 8'h3C;
    localparam logic [7:0] PIN_A = 8'hF0, PIN_B = 8'h0F, PIN_C = 8'h96;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_oe;
    logic [W-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
    logic [W-1:0] pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    ppio_ctrl #(.PORT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .addr(addr),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // A full write: strobe low for one cycle, rising while selected.
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; addr = a; din = d; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr = a;
        #1 d = dout;
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
    endtask

    function automatic logic [7:0] exp_port(input logic in_dir_hi, input logic in_dir_lo,
                                             input logic [7:0] pin, input logic [7:0] lat);
        exp_port = {in_dir_hi ? pin[7:4] : lat[7:4], in_dir_lo ? pin[3:0] : lat[3:0]};
    endfunction

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        if (!done) begin
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 oe", {pa_oe, pb_oe, pc_oe}, 24'h0);
        check("R1 lat", {pa_out, pb_out, pc_out}, 24'h0);
        bus_read(2'd3, rd);
        check("R1 ctl", rd, 8'h9B);

        // R9 idle bus
        @(negedge clk);
        check("R9 idle", {dout_oe, dout}, 9'h0);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R9 unselected", dout_oe, 1'b0);
        rd_n = 1'b1;

        pa_in = PIN_A; pb_in = PIN_B; pc_in = PIN_C;
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] cw;
            cw = VEC_CTL[i];
            bus_write(2'd3, cw);
            // R6 mode word cleared latches
            check("R6 clear", {pa_out, pb_out, pc_out}, 24'h0);
            // R3 R4 enables from direction bits
            check("R4 pa_oe", pa_oe, {8{~cw[4]}});
            check("R4 pb_oe", pb_oe, {8{~cw[1]}});
            check("R4 pc_oe", pc_oe, {{4{~cw[3]}}, {4{~cw[0]}}});
            if (cw == 8'h80) check("R3 all out", {pa_oe, pb_oe, pc_oe}, 24'hFFFFFF);
            // R5 readback
            bus_read(2'd3, rd);
            check("R5 ctl", rd, cw);
            // R2 address decode
            bus_write(2'd0, LAT_A);
            bus_write(2'd1, LAT_B);
            bus_write(2'd2, LAT_C);
            check("R2 lat", {pa_out, pb_out, pc_out}, {LAT_A, LAT_B, LAT_C});
            // R8 read mux
            bus_read(2'd0, rd);
            check("R8 A", rd, exp_port(cw[4], cw[4], PIN_A, LAT_A));
            bus_read(2'd1, rd);
            check("R8 B", rd, exp_port(cw[1], cw[1], PIN_B, LAT_B));
            bus_read(2'd2, rd);
            check("R8 C", rd, exp_port(cw[3], cw[0], PIN_C, LAT_C));
        end

        // R7 single-bit commands
        bus_write(2'd3, 8'h80);
        bus_write(2'd0, 8'h11);
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'h0F);
        check("R7 set bit7", pc_out, 8'h80);
        bus_write(2'd3, 8'h05);
        check("R7 set bit2", pc_out, 8'h84);
        bus_write(2'd3, 8'h04);
        check("R7 clr bit2", pc_out, 8'h80);
        check("R7 port A kept", pa_out, 8'h11);
        bus_read(2'd3, rd);
        check("R7 ctl kept", rd, 8'h80);

        // R10 strobe with chip deselected
        @(negedge clk); cs_n = 1'b1; addr = 2'd0; din = 8'hEE; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        check("R10 deselected", pa_out, 8'h11);
        // R10 held strobe only acts on release
        @(negedge clk); cs_n = 1'b0; addr = 2'd0; din = 8'h6A; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 held low", pa_out, 8'h11);
        wr_n = 1'b1;
        @(negedge clk); cs_n = 1'b1;
        check("R10 on rise", pa_out, 8'h6A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule